// File: doc/BRIEF.md
# Broadcast Read Splitter for a Single-Port Constant Cache

This block sits between a warp of 32 lanes and a small read-only cache that can look up only one word address per cycle. A warp presents one address per lane plus an active mask in a single handshake. The block then works through the distinct addresses among the active lanes. It serves one distinct address per cycle, and the returned word goes to every lane that asked for that same address. A warp whose active lanes all name one cached word therefore finishes in a single lookup. A warp with N distinct addresses needs at least N lookups.

The cache is direct-mapped and starts empty. A lookup that misses stalls the walk and reads the whole line over a valid/ready request channel to a backing memory. It then keeps that line, so the same lookup hits on the next cycle. The warp side can never write into the cache. An invalidate input drops every line in one cycle. Cache depth, line length, lane count and widths are parameters.

Top module: `bcastReadUnit`

## Requirements
- R1: After reset the unit is idle: `busy` is 0, `reqReady` is 1, `rspValid` is 0 and `memReqValid` is 0.
- R2: A warp is accepted only in a cycle with `reqValid` high while `reqReady` is high, and `reqReady` is 0 whenever `busy` is 1. A request presented while busy has no effect on any response, and it is not taken up later.
- R3: Each accepted warp produces exactly one `rspValid` cycle per distinct word address among its active lanes, after which `busy` returns to 0.
- R4: In each response, `rspLaneMask` has a 1 in bit i exactly for the not-yet-served active lanes whose address equals the one being served. Every active lane is delivered exactly once, with the backing memory word at its address. Inactive lanes are never delivered.
- R5: Distinct addresses are served in increasing order of the lowest-numbered lane that holds them.
- R6: When every address of a warp hits, a warp with N distinct addresses keeps `busy` high for exactly N cycles. A warp with one shared address finishes in one cycle.
- R7: A miss issues a line read with `memReqAddr` equal to the word address with its low log2(LINE_WORDS) bits dropped. `memReqValid` and `memReqAddr` hold steady until `memReqReady` is seen. The returned `memRspData` holds word w of the line in bits [w*DATA_W +: DATA_W].
- R8: A fetched line stays resident. Later reads of any word in it cause no further fetch until it is evicted or invalidated.
- R9: The cache holds nothing after reset, so the first read of every line fetches it.
- R10: A one-cycle `invalidate` pulse drops every resident line, so the next read of any line fetches it again.
- R11: The cache is direct-mapped. Line index is address bits [log2(LINE_WORDS) +: log2(NUM_LINES)]. Two lines with the same index and different upper bits evict each other.
- R12: A warp with an all-zero active mask is not taken up. It produces no response and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invalidate | input | 1 | Drop all resident lines |
| reqValid | input | 1 | Warp request present |
| reqReady | output | 1 | Unit can accept a warp |
| reqMask | input | LANES | Active lane mask |
| reqAddr | input | LANES*ADDR_W | Word address per lane, lane i in bits [i*ADDR_W +: ADDR_W] |
| busy | output | 1 | A warp is still being served |
| rspValid | output | 1 | A broadcast response is present this cycle |
| rspLaneMask | output | LANES | Lanes receiving `rspData` |
| rspData | output | DATA_W | Word broadcast to the masked lanes |
| memReqValid | output | 1 | Line read request |
| memReqReady | input | 1 | Backing memory takes the request |
| memReqAddr | output | ADDR_W-log2(LINE_WORDS) | Line address to read |
| memRspValid | input | 1 | Line data returning |
| memRspData | input | LINE_WORDS*DATA_W | Returned line |

## Verification
The bench targets warps whose lanes repeat addresses in interleaved patterns. A splitter that compared only neighbouring lanes, or cleared only the chosen lane, would then emit extra responses or deliver some lanes twice. It counts lookups on all-hit warps: a design that spent an extra cycle per address, or fetched on a hit, would miss the exact N-cycle figure and the zero-fetch count. It also drives two lines that share an index, an invalidate pulse, a request raised while busy and an empty mask. A cache that ignored the tag, kept stale lines, latched a second warp or went busy on nothing would each show a wrong fetch count, a wrong delivery or a spurious response.

// File: rtl/bcastPkg.sv
package bcastPkg;

  // Strobes issued by the control FSM to the datapath each cycle
  typedef struct packed {
    logic load;      // capture a new warp
    logic consume;   // retire the currently selected address group
    logic fill;      // write the returned line into the cache
    logic clearAll;  // drop every valid bit
  } dpCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_FREQ  = 2'd2,
    ST_FWAIT = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/bcastDatapath.sv
module bcastDatapath
  import bcastPkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpCmd_t                            cmd,
  input  logic [LANES*ADDR_W-1:0]           reqAddr,
  input  logic [LANES-1:0]                  reqMask,
  input  logic [LINE_WORDS*DATA_W-1:0]      memRspData,
  output logic [LANES-1:0]                  rspLaneMask,
  output logic [DATA_W-1:0]                 rspData,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] memLineAddr,
  output logic                              pendingEmpty,
  output logic                              hit,
  output logic                              lastGroup,
  output logic                              reqMaskEmpty
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LANE_W = $clog2(LANES);

  // Warp state
  logic [LANES-1:0][ADDR_W-1:0] laneAddr;
  logic [LANES-1:0]             pending;

  // Cache storage
  logic [NUM_LINES-1:0]                         lineValid;
  logic [NUM_LINES-1:0][TAG_W-1:0]              lineTag;
  logic [NUM_LINES-1:0][LINE_WORDS-1:0][DATA_W-1:0] lineData;

  // Selection of the current group
  logic [LANE_W-1:0] selIdx;
  logic [ADDR_W-1:0] selAddr;
  logic [OFF_W-1:0]  selOff;
  logic [IDX_W-1:0]  selIndex;
  logic [TAG_W-1:0]  selTag;
  logic [LANES-1:0]  matchMask;

  // Lowest-index pending lane wins
  always_comb begin
    selIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) selIdx = LANE_W'(i);
    end
  end

  assign selAddr  = laneAddr[selIdx];
  assign selOff   = selAddr[OFF_W-1:0];
  assign selIndex = selAddr[OFF_W +: IDX_W];
  assign selTag   = selAddr[ADDR_W-1 -: TAG_W];

  // Every pending lane sharing the selected address joins the group
  for (genvar g = 0; g < LANES; g++) begin : gMatch
    assign matchMask[g] = pending[g] && (laneAddr[g] == selAddr);
  end

  assign hit          = lineValid[selIndex] && (lineTag[selIndex] == selTag);
  assign lastGroup    = (pending & ~matchMask) == '0;
  assign pendingEmpty = (pending == '0);
  assign reqMaskEmpty = (reqMask == '0);
  assign rspLaneMask  = cmd.consume ? matchMask : '0;
  assign rspData      = lineData[selIndex][selOff];
  assign memLineAddr  = selAddr[ADDR_W-1:OFF_W];

  // Lane address capture
  always_ff @(posedge clk) begin
    if (cmd.load) laneAddr <= reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else if (cmd.load) begin
      pending <= reqMask;
    end else if (cmd.consume) begin
      pending <= pending & ~matchMask;
    end
  end

  // Valid bits: invalidate wins over a same-cycle fill
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clearAll) begin
      lineValid <= '0;
    end else if (cmd.fill) begin
      lineValid[selIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.fill) begin
      lineTag[selIndex]  <= selTag;
      lineData[selIndex] <= memRspData;
    end
  end

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fill && !cmd.clearAll) |=> hit) else $error("fill did not hit");  // R8

  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    cmd.consume |-> ((matchMask & (pending & (~pending + 1'b1))) != '0))
    else $error("group skips lowest lane");  // R5

  AST_SERVE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.consume |=> ((pending & $past(matchMask)) == '0))
    else $error("served lane still pending");  // R4

endmodule

// File: rtl/bcastCtrl.sv
module bcastCtrl
  import bcastPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   invalidate,
  input  logic   reqValid,
  input  logic   memReqReady,
  input  logic   memRspValid,
  input  logic   pendingEmpty,
  input  logic   hit,
  input  logic   lastGroup,
  input  logic   reqMaskEmpty,
  output dpCmd_t cmd,
  output logic   reqReady,
  output logic   busy,
  output logic   rspValid,
  output logic   memReqValid
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    cmd          = '0;
    cmd.clearAll = invalidate;
    rspValid     = 1'b0;
    memReqValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && !reqMaskEmpty) begin
          cmd.load  = 1'b1;
          stateNext = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (pendingEmpty) begin
          stateNext = ST_IDLE;
        end else if (hit) begin
          cmd.consume = 1'b1;
          rspValid    = 1'b1;
          if (lastGroup) stateNext = ST_IDLE;
        end else begin
          stateNext = ST_FREQ;
        end
      end
      ST_FREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (memRspValid) begin
          cmd.fill  = 1'b1;
          stateNext = ST_SERVE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign reqReady = (state == ST_IDLE);

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid) else $error("request dropped");  // R7

  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> pendingEmpty) else $error("idle with lanes left");  // R3

endmodule

// File: rtl/bcastReadUnit.sv
module bcastReadUnit
  import bcastPkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 invalidate,
  input  logic                                 reqValid,
  output logic                                 reqReady,
  input  logic [LANES-1:0]                     reqMask,
  input  logic [LANES*ADDR_W-1:0]              reqAddr,
  output logic                                 busy,
  output logic                                 rspValid,
  output logic [LANES-1:0]                     rspLaneMask,
  output logic [DATA_W-1:0]                    rspData,
  output logic                                 memReqValid,
  input  logic                                 memReqReady,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0] memReqAddr,
  input  logic                                 memRspValid,
  input  logic [LINE_WORDS*DATA_W-1:0]         memRspData
);

  dpCmd_t cmd;
  logic   pendingEmpty, hit, lastGroup, reqMaskEmpty;

  bcastCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .invalidate  (invalidate),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .pendingEmpty(pendingEmpty),
    .hit         (hit),
    .lastGroup   (lastGroup),
    .reqMaskEmpty(reqMaskEmpty),
    .cmd         (cmd),
    .reqReady    (reqReady),
    .busy        (busy),
    .rspValid    (rspValid),
    .memReqValid (memReqValid)
  );

  bcastDatapath #(
    .LANES     (LANES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .reqAddr     (reqAddr),
    .reqMask     (reqMask),
    .memRspData  (memRspData),
    .rspLaneMask (rspLaneMask),
    .rspData     (rspData),
    .memLineAddr (memReqAddr),
    .pendingEmpty(pendingEmpty),
    .hit         (hit),
    .lastGroup   (lastGroup),
    .reqMaskEmpty(reqMaskEmpty)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rspValid && !memReqValid)) else $error("activity while idle");  // R1

  AST_MADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)) else $error("line address moved");  // R7

  AST_RSP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspLaneMask != '0)) else $error("empty broadcast");  // R4

endmodule

// File: tb/bcastReadUnit_test.sv
`timescale 1ns/1ps
module bcastReadUnit_test;
  localparam int LANES = 32, ADDR_W = 16, DATA_W = 32, NUM_LINES = 8, LINE_WORDS = 4;
  localparam int LAT = 3;

  logic clk = 1'b0, rstN = 1'b0, invalidate = 1'b0, reqValid = 1'b0;
  logic reqReady, busy, rspValid, memReqValid;
  logic [LANES-1:0] reqMask = '0;
  logic [LANES-1:0][ADDR_W-1:0] curAddr = '0;
  logic [LANES-1:0][ADDR_W-1:0] expAddr = '0;
  logic [LANES*ADDR_W-1:0] reqAddr;
  logic [LANES-1:0] rspLaneMask;
  logic [DATA_W-1:0] rspData;
  logic memReqReady = 1'b0, memRspValid = 1'b0;
  logic [ADDR_W-3:0] memReqAddr;
  logic [LINE_WORDS*DATA_W-1:0] memRspData = '0;

  assign reqAddr = curAddr;

  always #4 clk = ~clk;  // 125 MHz

  bcastReadUnit #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS)) uut (
    .clk(clk), .rstN(rstN), .invalidate(invalidate), .reqValid(reqValid),
    .reqReady(reqReady), .reqMask(reqMask), .reqAddr(reqAddr), .busy(busy),
    .rspValid(rspValid), .rspLaneMask(rspLaneMask), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData));

  int checks = 0, fails = 0;
  int laneHits [LANES];
  logic [DATA_W-1:0] laneData [LANES];
  int respCount = 0, fetchCount = 0, busyCycles = 0, prevLow = -1;
  bit orderErr = 0, finished = 0;

  function automatic logic [DATA_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats();
    for (int l = 0; l < LANES; l++) begin laneHits[l] = 0; laneData[l] = '0; end
    respCount = 0; fetchCount = 0; busyCycles = 0; prevLow = -1; orderErr = 0;
  endtask

  // Backing memory: one cycle of not-ready, then accept, then LAT cycles to data
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        logic [ADDR_W-3:0] ln;
        @(negedge clk);
        memReqReady = 1'b1;
        ln = memReqAddr;
        @(negedge clk);
        memReqReady = 1'b0;
        fetchCount++;
        repeat (LAT) @(negedge clk);
        for (int w = 0; w < LINE_WORDS; w++) memRspData[w*DATA_W +: DATA_W] = wordOf({ln, 2'(w)});
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // Response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (busy) busyCycles++;
      if (rspValid) begin
        int low = -1;
        respCount++;
        for (int l = LANES - 1; l >= 0; l--) begin
          if (rspLaneMask[l]) begin
            laneHits[l]++;
            laneData[l] = rspData;
            low = l;
          end
        end
        if (low <= prevLow) orderErr = 1;
        prevLow = low;
      end
    end
  end

  task automatic checkLanes(input string req);
    int bad = -1, act = 0, exp = 0;
    for (int l = 0; l < LANES; l++) begin
      if (bad < 0) begin
        if (reqMask[l] && (laneHits[l] != 1 || laneData[l] != wordOf(expAddr[l]))) begin
          bad = l; act = int'(laneData[l]); exp = int'(wordOf(expAddr[l]));
        end else if (!reqMask[l] && laneHits[l] != 0) begin
          bad = l; act = laneHits[l]; exp = 0;
        end
      end
    end
    check(bad < 0, req, $sformatf("lane delivery (lane %0d)", bad), act, exp);
  endtask

  // Issue one warp; optionally raise a second request while busy
  task automatic runWarp(input logic [LANES-1:0] m, input bit intrude);
    int t = 0;
    clearStats();
    @(negedge clk);
    reqMask = m; expAddr = curAddr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (intrude) begin
      for (int k = 0; k < 2; k++) begin
        check(!reqReady, "R2", "reqReady while busy", int'(reqReady), 0);
        for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0777 + 16'(l);
        reqValid = 1'b1;
        @(negedge clk);
      end
      reqValid = 1'b0;
    end
    while (busy && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, "R3", "warp completion timeout", t, 0);
  endtask

  task automatic expectStats(input string req, input int expResp, input int expFetch, input int expBusy);
    check(respCount == expResp, req, "response count", respCount, expResp);
    check(fetchCount == expFetch, req, "fetch count", fetchCount, expFetch);
    if (expBusy >= 0) check(busyCycles == expBusy, req, "busy cycles", busyCycles, expBusy);
    check(!orderErr, "R5", "response order", int'(orderErr), 0);
  endtask

  task automatic testReset();
    check(!busy && reqReady && !rspValid && !memReqValid, "R1", "reset state",
          {busy, reqReady, rspValid, memReqValid}, 4'b0100);
  endtask

  task automatic testColdBroadcast();
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0010;
    runWarp('1, 0);
    expectStats("R9", 1, 1, -1);
    checkLanes("R4");
  endtask

  task automatic testHitSingle();
    runWarp('1, 0);
    expectStats("R6", 1, 0, 1);
    checkLanes("R4");
  endtask

  task automatic testSameLineMix();
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0010 + 16'(l % 4);
    runWarp('1, 0);
    expectStats("R8", 4, 0, 4);  // R6: four distinct hits take four cycles
    checkLanes("R3");
  endtask

  task automatic testSparseMask();
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0200 + 16'((l % 3) * 4);
    for (int l = 0; l < LANES; l++) if (!(32'hA5A5_0F0F >> l & 1)) curAddr[l] = 16'h7FFF;
    runWarp(32'hA5A5_0F0F, 0);
    expectStats("R7", 3, 3, -1);
    checkLanes("R4");
  endtask

  task automatic testConflict();
    for (int l = 0; l < LANES; l++) curAddr[l] = (l % 2 == 0) ? 16'h0040 : 16'h0141;
    runWarp('1, 0);
    expectStats("R11", 2, 2, -1);
    checkLanes("R11");
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0042;
    runWarp('1, 0);
    expectStats("R11", 1, 1, -1);
    checkLanes("R11");
  endtask

  task automatic testInvalidate();
    @(negedge clk); invalidate = 1'b1;
    @(negedge clk); invalidate = 1'b0;
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0013;
    runWarp('1, 0);
    expectStats("R10", 1, 1, -1);
    checkLanes("R10");
    runWarp('1, 0);
    expectStats("R8", 1, 0, 1);
  endtask

  task automatic testBusyIgnore();
    for (int l = 0; l < LANES; l++) curAddr[l] = 16'h0300 + 16'(l & 1);
    runWarp('1, 1);
    expectStats("R2", 2, 1, -1);
    checkLanes("R2");
    clearStats();
    repeat (4) @(negedge clk);
    check(busyCycles == 0 && respCount == 0, "R2", "late uptake of blocked request", busyCycles, 0);
  endtask

  task automatic testZeroMask();
    clearStats();
    @(negedge clk);
    reqMask = '0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(busyCycles == 0, "R12", "busy on empty mask", busyCycles, 0);
    check(respCount == 0, "R12", "responses on empty mask", respCount, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testColdBroadcast();
    testHitSingle();
    testSameLineMix();
    testSparseMask();
    testConflict();
    testInvalidate();
    testBusyIgnore();
    testZeroMask();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R3", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule